// File: doc/BRIEF.md
# Address-Range Burst Compression Router

This block sits on the memory path between a requesting processing block and a memory port. For every burst it decides whether the data should travel through an external compression engine. Control software declares a few image buffers in advance. For each buffer it sets a lower and upper address, an enable flag and the compressed transfer size it wants. The router looks up each burst's start address in that table. It never alters the address and keeps nothing from one burst to the next.

When the address falls in a declared buffer, the router does three things. It shrinks the memory-side length to the buffer's compressed size. It starts the codec in the right direction. It steers the beats through the codec: requester to codec to memory on writes, and memory to codec to requester on reads. When no buffer matches, address, length and beats go straight through. The requester always sees its own burst length reported back on completion. Table writes that arrive while a burst is in progress wait until the burst finishes.

Top module: `burst_comp_router`

## Requirements
- R1: The memory-side request address equals the start address of the accepted burst, whether or not it is compressed.
- R2: A table entry matches when its enable flag is set, its target size is nonzero, and lower <= start address < upper. The upper bound is exclusive.
- R3: When several entries match, the entry with the smallest index decides the target size.
- R4: On a match, the memory-side length is the smaller of the entry's target and the requested length. In the cycle the memory request is accepted, the codec start pulse fires, with direction 1 for write (compress) and 0 for read (decompress).
- R5: On no match, the memory-side length equals the requested length. Write beats go from the requester to memory, and read beats from memory to the requester, in the same cycle and unchanged. The codec sees no valid beat and no start pulse.
- R6: On a compressed write, requester beats go to the codec input and codec output beats go to memory. The requester supplies length/4 beats and memory receives target-length/4 beats, with 32-bit words.
- R7: On a compressed read, memory beats go to the codec input and codec output beats go to the requester. Memory supplies packed-length/4 beats and the requester receives requested-length/4 beats.
- R8: `cfg_ready` is low from the cycle after a request is accepted until the burst completes. A table write held during that time takes effect at the first clock edge after completion. Field select codes: 0 lower, 1 upper, 2 target bytes, 3 enable (any nonzero value enables).
- R9: `ip_done` pulses for one cycle, in the cycle after the final beat, with `ip_done_len` equal to the originally requested length.
- R10: A burst's routing depends only on its own address and the table. A bypass burst after a compressed one is pure pass-through.
- R11: After reset, all entries are disabled, the block is idle, and `cfg_ready` and `ip_req_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table write request, held until taken |
| cfg_idx | input | 2 | Table entry index |
| cfg_sel | input | 2 | Field select (0 lower, 1 upper, 2 target, 3 enable) |
| cfg_wdata | input | 32 | Field value |
| cfg_ready | output | 1 | High when a table write is taken this cycle |
| ip_req_valid | input | 1 | Requester burst request |
| ip_req_ready | output | 1 | Request accepted |
| ip_req_write | input | 1 | 1 write, 0 read |
| ip_req_addr | input | 32 | Burst start address |
| ip_req_len | input | 12 | Burst length in bytes |
| mem_req_valid | output | 1 | Memory-side request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | Memory-side direction |
| mem_req_addr | output | 32 | Memory-side address |
| mem_req_len | output | 12 | Memory-side length in bytes |
| ip_wvalid | input | 1 | Requester write beat valid |
| ip_wdata | input | 32 | Requester write beat |
| ip_wready | output | 1 | Requester write beat taken |
| mem_wvalid | output | 1 | Memory write beat valid |
| mem_wdata | output | 32 | Memory write beat |
| mem_wready | input | 1 | Memory write beat taken |
| mem_rvalid | input | 1 | Memory read beat valid |
| mem_rdata | input | 32 | Memory read beat |
| mem_rready | output | 1 | Memory read beat taken |
| ip_rvalid | output | 1 | Requester read beat valid |
| ip_rdata | output | 32 | Requester read beat |
| ip_rready | input | 1 | Requester read beat taken |
| cdc_start | output | 1 | Codec start pulse |
| cdc_dir | output | 1 | Codec direction, 1 compress |
| cdc_raw_len | output | 12 | Uncompressed length in bytes |
| cdc_pkd_len | output | 12 | Compressed length in bytes |
| cdc_in_valid | output | 1 | Codec input beat valid |
| cdc_in_data | output | 32 | Codec input beat |
| cdc_in_ready | input | 1 | Codec input beat taken |
| cdc_out_valid | input | 1 | Codec output beat valid |
| cdc_out_data | input | 32 | Codec output beat |
| cdc_out_ready | output | 1 | Codec output beat taken |
| ip_done | output | 1 | Burst complete pulse |
| ip_done_len | output | 12 | Length reported to requester |

## Verification
The memory request, its address and length, and the codec start pulse all appear in the first cycle after the requester's request is taken. They are checked there, before that cycle's edge. Beat routing is combinational, so each data path is compared in the same cycle the stimulus beat is driven, 2 ns after the falling edge. The completion pulse and the release of `cfg_ready` are checked one cycle after the final beat. A table write stalled during a burst is shown to take effect by the next burst's memory-side length.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_XFER} bcr_state_e;
  localparam logic [1:0] SEL_LOWER  = 2'd0;
  localparam logic [1:0] SEL_UPPER  = 2'd1;
  localparam logic [1:0] SEL_TARGET = 2'd2;
  localparam logic [1:0] SEL_ENABLE = 2'd3;
endpackage

// File: rtl/bcr_range_table.sv
module bcr_range_table
  import bcr_pkg::*;
#(
  parameter int NR = 4,
  parameter int AW = 32,
  localparam int IDXW = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDXW-1:0]        wr_idx,
  input  logic [1:0]             wr_sel,
  input  logic [AW-1:0]          wr_data,
  output logic [NR-1:0][AW-1:0]  lower_o,
  output logic [NR-1:0][AW-1:0]  upper_o,
  output logic [NR-1:0][AW-1:0]  target_o,
  output logic [NR-1:0]          enable_o
);
  for (genvar i = 0; i < NR; i++) begin : g_entry
    logic hit_w;
    assign hit_w = wr_en && (wr_idx == IDXW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lower_o[i]  <= '0;
        upper_o[i]  <= '0;
        target_o[i] <= '0;
        enable_o[i] <= 1'b0;
      end else if (hit_w) begin
        case (wr_sel)
          SEL_LOWER:  lower_o[i]  <= wr_data;
          SEL_UPPER:  upper_o[i]  <= wr_data;
          SEL_TARGET: target_o[i] <= wr_data;
          default:    enable_o[i] <= |wr_data;
        endcase
      end
    end
  end
endmodule

// File: rtl/bcr_range_match.sv
module bcr_range_match #(
  parameter int NR = 4,
  parameter int AW = 32
) (
  input  logic [AW-1:0]          addr,
  input  logic [NR-1:0][AW-1:0]  lower,
  input  logic [NR-1:0][AW-1:0]  upper,
  input  logic [NR-1:0][AW-1:0]  target,
  input  logic [NR-1:0]          enable,
  output logic                   hit,
  output logic [AW-1:0]          hit_target,
  output logic [NR-1:0]          grant
);
  function automatic logic in_window(input logic [AW-1:0] a, input logic [AW-1:0] lo,
                                     input logic [AW-1:0] hi);
    return (lo <= a) && (a < hi);
  endfunction

  logic [NR-1:0] cand;
  for (genvar i = 0; i < NR; i++) begin : g_cand
    assign cand[i] = enable[i] && (target[i] != '0) && in_window(addr, lower[i], upper[i]);
  end

  always_comb begin
    grant      = '0;
    hit_target = '0;
    for (int i = NR - 1; i >= 0; i--) begin
      if (cand[i]) begin
        grant      = '0;
        grant[i]   = 1'b1;
        hit_target = target[i];
      end
    end
  end

  assign hit = |cand;
endmodule

// File: rtl/bcr_data_xbar.sv
module bcr_data_xbar #(
  parameter int DW = 32
) (
  input  logic          active,
  input  logic          comp,
  input  logic          write,
  input  logic          src_open,
  input  logic          dst_open,
  input  logic          ip_wvalid,
  input  logic [DW-1:0] ip_wdata,
  output logic          ip_wready,
  output logic          mem_wvalid,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_wready,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_rready,
  output logic          ip_rvalid,
  output logic [DW-1:0] ip_rdata,
  input  logic          ip_rready,
  output logic          cdc_in_valid,
  output logic [DW-1:0] cdc_in_data,
  input  logic          cdc_in_ready,
  input  logic          cdc_out_valid,
  input  logic [DW-1:0] cdc_out_data,
  output logic          cdc_out_ready,
  output logic          src_fire,
  output logic          dst_fire
);
  logic          s_valid, s_ready, d_valid, d_ready, pass;
  logic [DW-1:0] s_data, d_data;

  always_comb begin
    s_valid = write ? ip_wvalid : mem_rvalid;
    s_data  = write ? ip_wdata  : mem_rdata;
    d_ready = write ? mem_wready : ip_rready;
    pass    = active && src_open && dst_open;
    if (comp) begin
      cdc_in_valid  = active && s_valid && src_open;
      s_ready       = active && cdc_in_ready && src_open;
      d_valid       = active && cdc_out_valid && dst_open;
      cdc_out_ready = active && d_ready && dst_open;
      d_data        = cdc_out_data;
    end else begin
      cdc_in_valid  = 1'b0;
      cdc_out_ready = 1'b0;
      d_valid       = pass && s_valid;
      s_ready       = pass && d_ready;
      d_data        = s_data;
    end
  end

  assign cdc_in_data = s_data;
  assign ip_wready   = write && s_ready;
  assign mem_rready  = !write && s_ready;
  assign mem_wvalid  = write && d_valid;
  assign ip_rvalid   = !write && d_valid;
  assign mem_wdata   = d_data;
  assign ip_rdata    = d_data;
  assign src_fire    = s_valid && s_ready;
  assign dst_fire    = d_valid && d_ready;
endmodule

// File: rtl/burst_comp_router.sv
module burst_comp_router
  import bcr_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 12,
  parameter int DW = 32,
  parameter int NR = 4,
  localparam int IDXW = (NR > 1) ? $clog2(NR) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IDXW-1:0] cfg_idx,
  input  logic [1:0]      cfg_sel,
  input  logic [AW-1:0]   cfg_wdata,
  output logic            cfg_ready,
  input  logic            ip_req_valid,
  output logic            ip_req_ready,
  input  logic            ip_req_write,
  input  logic [AW-1:0]   ip_req_addr,
  input  logic [LW-1:0]   ip_req_len,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [AW-1:0]   mem_req_addr,
  output logic [LW-1:0]   mem_req_len,
  input  logic            ip_wvalid,
  input  logic [DW-1:0]   ip_wdata,
  output logic            ip_wready,
  output logic            mem_wvalid,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_wready,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata,
  output logic            mem_rready,
  output logic            ip_rvalid,
  output logic [DW-1:0]   ip_rdata,
  input  logic            ip_rready,
  output logic            cdc_start,
  output logic            cdc_dir,
  output logic [LW-1:0]   cdc_raw_len,
  output logic [LW-1:0]   cdc_pkd_len,
  output logic            cdc_in_valid,
  output logic [DW-1:0]   cdc_in_data,
  input  logic            cdc_in_ready,
  input  logic            cdc_out_valid,
  input  logic [DW-1:0]   cdc_out_data,
  output logic            cdc_out_ready,
  output logic            ip_done,
  output logic [LW-1:0]   ip_done_len
);
  localparam int BSH = $clog2(DW / 8);

  function automatic logic [LW-1:0] beats_of(input logic [LW-1:0] len);
    return len >> BSH;
  endfunction

  function automatic logic [LW-1:0] packed_len(input logic [LW-1:0] req, input logic [AW-1:0] tgt);
    if (tgt < AW'(req)) return tgt[LW-1:0];
    return req;
  endfunction

  bcr_state_e state;
  logic            r_write, r_hit;
  logic [AW-1:0]   r_addr;
  logic [LW-1:0]   r_len, r_mlen, src_cnt, dst_cnt;

  logic [NR-1:0][AW-1:0] t_lower, t_upper, t_target;
  logic [NR-1:0]         t_enable;
  logic                  m_hit;
  logic [AW-1:0]         m_target;
  logic [NR-1:0]         range_grant;

  // named internal events
  logic burst_busy, burst_hit, req_take, cfg_take, in_xfer, last_beat;
  logic src_open, dst_open, src_fire, dst_fire;
  logic [LW-1:0] src_need, dst_need;

  assign burst_busy   = (state != ST_IDLE);
  assign burst_hit    = burst_busy && r_hit;
  assign in_xfer      = (state == ST_XFER);
  assign cfg_ready    = !burst_busy;
  assign cfg_take     = cfg_we && cfg_ready;
  assign ip_req_ready = !burst_busy && !cfg_we;
  assign req_take     = ip_req_valid && ip_req_ready;

  bcr_range_table #(.NR(NR), .AW(AW)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_take), .wr_idx(cfg_idx), .wr_sel(cfg_sel),
    .wr_data(cfg_wdata), .lower_o(t_lower), .upper_o(t_upper), .target_o(t_target),
    .enable_o(t_enable)
  );

  bcr_range_match #(.NR(NR), .AW(AW)) u_match (
    .addr(ip_req_addr), .lower(t_lower), .upper(t_upper), .target(t_target),
    .enable(t_enable), .hit(m_hit), .hit_target(m_target), .grant(range_grant)
  );

  assign src_need  = r_write ? beats_of(r_len) : beats_of(r_mlen);
  assign dst_need  = r_write ? beats_of(r_mlen) : beats_of(r_len);
  assign src_open  = (src_cnt != src_need);
  assign dst_open  = (dst_cnt != dst_need);
  assign last_beat = in_xfer && ((src_cnt + LW'(src_fire)) == src_need)
                             && ((dst_cnt + LW'(dst_fire)) == dst_need);

  bcr_data_xbar #(.DW(DW)) u_xbar (
    .active(in_xfer), .comp(r_hit), .write(r_write), .src_open(src_open), .dst_open(dst_open),
    .ip_wvalid(ip_wvalid), .ip_wdata(ip_wdata), .ip_wready(ip_wready),
    .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata), .mem_wready(mem_wready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rready(mem_rready),
    .ip_rvalid(ip_rvalid), .ip_rdata(ip_rdata), .ip_rready(ip_rready),
    .cdc_in_valid(cdc_in_valid), .cdc_in_data(cdc_in_data), .cdc_in_ready(cdc_in_ready),
    .cdc_out_valid(cdc_out_valid), .cdc_out_data(cdc_out_data), .cdc_out_ready(cdc_out_ready),
    .src_fire(src_fire), .dst_fire(dst_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      r_write     <= 1'b0;
      r_hit       <= 1'b0;
      r_addr      <= '0;
      r_len       <= '0;
      r_mlen      <= '0;
      src_cnt     <= '0;
      dst_cnt     <= '0;
      ip_done     <= 1'b0;
      ip_done_len <= '0;
    end else begin
      ip_done <= 1'b0;
      case (state)
        ST_IDLE: if (req_take) begin
          r_write <= ip_req_write;
          r_addr  <= ip_req_addr;
          r_len   <= ip_req_len;
          r_hit   <= m_hit;
          r_mlen  <= m_hit ? packed_len(ip_req_len, m_target) : ip_req_len;
          src_cnt <= '0;
          dst_cnt <= '0;
          state   <= ST_ISSUE;
        end
        ST_ISSUE: if (mem_req_ready) state <= ST_XFER;
        default: begin
          src_cnt <= src_cnt + LW'(src_fire);
          dst_cnt <= dst_cnt + LW'(dst_fire);
          if (last_beat) begin
            state       <= ST_IDLE;
            ip_done     <= 1'b1;
            ip_done_len <= r_len;
          end
        end
      endcase
    end
  end

  assign mem_req_valid = (state == ST_ISSUE);
  assign mem_req_write = r_write;
  assign mem_req_addr  = r_addr;
  assign mem_req_len   = r_mlen;
  assign cdc_start     = mem_req_valid && mem_req_ready && r_hit;
  assign cdc_dir       = r_write;
  assign cdc_raw_len   = r_len;
  assign cdc_pkd_len   = r_mlen;
endmodule

// File: rtl/bcr_chk.sv
module bcr_chk #(
  parameter int AW = 32,
  parameter int LW = 12,
  parameter int NR = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ip_req_valid,
  input logic          ip_req_ready,
  input logic [AW-1:0] ip_req_addr,
  input logic [LW-1:0] ip_req_len,
  input logic          mem_req_valid,
  input logic [AW-1:0] mem_req_addr,
  input logic [LW-1:0] mem_req_len,
  input logic          cfg_ready,
  input logic          cdc_in_valid,
  input logic          cdc_out_ready,
  input logic          cdc_start,
  input logic          ip_done,
  input logic [LW-1:0] ip_done_len,
  input logic          burst_busy,
  input logic          burst_hit,
  input logic [NR-1:0] range_grant
);
  logic [AW-1:0] cap_addr;
  logic [LW-1:0] cap_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_len  <= '0;
    end else if (ip_req_valid && ip_req_ready) begin
      cap_addr <= ip_req_addr;
      cap_len  <= ip_req_len;
    end
  end

  p_addr_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr == cap_addr);
  p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(range_grant));
  p_len_shrink_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_len <= cap_len);
  p_miss_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !burst_hit) |-> mem_req_len == cap_len);
  p_codec_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_hit |-> (!cdc_in_valid && !cdc_out_ready && !cdc_start));
  p_cfg_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    burst_busy |-> !cfg_ready);
  p_done_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ip_done |-> (ip_done_len == cap_len && !burst_busy));
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ip_done |=> !ip_done);
endmodule

bind burst_comp_router bcr_chk #(.AW(AW), .LW(LW), .NR(NR)) u_chk (
  .clk(clk), .rst_n(rst_n), .ip_req_valid(ip_req_valid), .ip_req_ready(ip_req_ready),
  .ip_req_addr(ip_req_addr), .ip_req_len(ip_req_len), .mem_req_valid(mem_req_valid),
  .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len), .cfg_ready(cfg_ready),
  .cdc_in_valid(cdc_in_valid), .cdc_out_ready(cdc_out_ready), .cdc_start(cdc_start),
  .ip_done(ip_done), .ip_done_len(ip_done_len), .burst_busy(burst_busy),
  .burst_hit(burst_hit), .range_grant(range_grant)
);

// File: tb/burst_comp_router_tb.sv
module burst_comp_router_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cfg_we = 0;
  logic [1:0]  cfg_idx = 0, cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic        cfg_ready;
  logic        ip_req_valid = 0, ip_req_write = 0, ip_req_ready;
  logic [31:0] ip_req_addr = 0;
  logic [11:0] ip_req_len = 0;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1;
  logic [31:0] mem_req_addr;
  logic [11:0] mem_req_len;
  logic        ip_wvalid = 0, ip_wready, mem_wvalid, mem_wready = 1;
  logic [31:0] ip_wdata = 0, mem_wdata;
  logic        mem_rvalid = 0, mem_rready, ip_rvalid, ip_rready = 1;
  logic [31:0] mem_rdata = 0, ip_rdata;
  logic        cdc_start, cdc_dir, cdc_in_valid, cdc_in_ready = 1, cdc_out_valid = 0, cdc_out_ready;
  logic [11:0] cdc_raw_len, cdc_pkd_len;
  logic [31:0] cdc_in_data, cdc_out_data = 0;
  logic        ip_done;
  logic [11:0] ip_done_len;

  burst_comp_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_ready(cfg_ready), .ip_req_valid(ip_req_valid),
    .ip_req_ready(ip_req_ready), .ip_req_write(ip_req_write), .ip_req_addr(ip_req_addr),
    .ip_req_len(ip_req_len), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr), .mem_req_len(mem_req_len),
    .ip_wvalid(ip_wvalid), .ip_wdata(ip_wdata), .ip_wready(ip_wready),
    .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata), .mem_wready(mem_wready),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rready(mem_rready),
    .ip_rvalid(ip_rvalid), .ip_rdata(ip_rdata), .ip_rready(ip_rready),
    .cdc_start(cdc_start), .cdc_dir(cdc_dir), .cdc_raw_len(cdc_raw_len),
    .cdc_pkd_len(cdc_pkd_len), .cdc_in_valid(cdc_in_valid), .cdc_in_data(cdc_in_data),
    .cdc_in_ready(cdc_in_ready), .cdc_out_valid(cdc_out_valid), .cdc_out_data(cdc_out_data),
    .cdc_out_ready(cdc_out_ready), .ip_done(ip_done), .ip_done_len(ip_done_len)
  );

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] m_lo [4];
  logic [31:0] m_hi [4];
  logic [31:0] m_tg [4];
  bit          m_en [4];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference: first enabled, nonzero-target window containing the address
  task automatic ref_lookup(input logic [31:0] a, input logic [11:0] l, output bit hit, output logic [11:0] ml);
    hit = 0;
    ml  = l;
    for (int i = 0; i < 4; i++) begin
      if (!hit && m_en[i] && m_tg[i] != 0 && a >= m_lo[i] && a < m_hi[i]) begin
        hit = 1;
        ml  = (m_tg[i] < {20'd0, l}) ? m_tg[i][11:0] : l;
      end
    end
  endtask

  task automatic cfg_write(input int idx, input int sel, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 2'(idx); cfg_sel = 2'(sel); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
    case (sel)
      0: m_lo[idx] = v;
      1: m_hi[idx] = v;
      2: m_tg[idx] = v;
      default: m_en[idx] = (v != 0);
    endcase
  endtask

  task automatic run_burst(input bit wr, input logic [31:0] a, input logic [11:0] l, input bit stall);
    bit hit;
    logic [11:0] ml;
    int nr, np, n;
    string tl;
    ref_lookup(a, l, hit, ml);
    tl = hit ? "R4" : "R5";
    nr = int'(l) / 4;
    np = int'(ml) / 4;
    n  = (nr > np) ? nr : np;
    @(negedge clk);
    ip_req_valid = 1; ip_req_write = wr; ip_req_addr = a; ip_req_len = l;
    #2 chk(ip_req_ready == 1, "R11 request accepted when idle", 32'(ip_req_ready), 1);
    @(negedge clk);
    ip_req_valid = 0;
    if (stall) begin
      cfg_we = 1; cfg_idx = 2'd3; cfg_sel = 2'd3; cfg_wdata = 32'd1;
    end
    #2;
    chk(mem_req_valid == 1, "R1 memory request raised", 32'(mem_req_valid), 1);
    chk(mem_req_addr == a, "R1 address unchanged", mem_req_addr, a);
    chk(mem_req_len == ml, {tl, " memory length"}, 32'(mem_req_len), 32'(ml));
    chk(mem_req_write == wr, "R1 direction", 32'(mem_req_write), 32'(wr));
    chk(cdc_start == hit, {tl, " codec start"}, 32'(cdc_start), 32'(hit));
    if (hit) chk(cdc_dir == wr, "R4 codec direction", 32'(cdc_dir), 32'(wr));
    chk(cfg_ready == 0, "R8 table locked in burst", 32'(cfg_ready), 0);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ip_wvalid = 0; mem_rvalid = 0; cdc_out_valid = 0;
      ip_wdata = {a[15:0], 16'(k)};
      mem_rdata = 32'hAE00_0000 | k;
      cdc_out_data = 32'hC0DE_0000 | k;
      if (wr && hit) begin
        ip_wvalid = (k < nr); cdc_out_valid = (k < np);
      end else if (!wr && hit) begin
        mem_rvalid = (k < np); cdc_out_valid = (k < nr);
      end else if (wr) ip_wvalid = 1;
      else mem_rvalid = 1;
      #2;
      chk(cfg_ready == 0, "R8 table locked in burst", 32'(cfg_ready), 0);
      if (wr && hit) begin
        chk(cdc_in_valid == (k < nr), "R6 codec input valid", 32'(cdc_in_valid), 32'(k < nr));
        if (k < nr) chk(cdc_in_data == ip_wdata, "R6 codec input data", cdc_in_data, ip_wdata);
        chk(ip_wready == (k < nr), "R6 requester ready", 32'(ip_wready), 32'(k < nr));
        chk(mem_wvalid == (k < np), "R6 memory write valid", 32'(mem_wvalid), 32'(k < np));
        if (k < np) chk(mem_wdata == cdc_out_data, "R6 memory gets codec data", mem_wdata, cdc_out_data);
      end else if (!wr && hit) begin
        chk(cdc_in_valid == (k < np), "R7 codec input valid", 32'(cdc_in_valid), 32'(k < np));
        if (k < np) chk(cdc_in_data == mem_rdata, "R7 codec input data", cdc_in_data, mem_rdata);
        chk(mem_rready == (k < np), "R7 memory read ready", 32'(mem_rready), 32'(k < np));
        chk(ip_rvalid == (k < nr), "R7 requester read valid", 32'(ip_rvalid), 32'(k < nr));
        if (k < nr) chk(ip_rdata == cdc_out_data, "R7 requester gets codec data", ip_rdata, cdc_out_data);
      end else if (wr) begin
        chk(mem_wvalid == 1, "R5 bypass write valid", 32'(mem_wvalid), 1);
        chk(mem_wdata == ip_wdata, "R5 bypass write data", mem_wdata, ip_wdata);
        chk(cdc_in_valid == 0, "R10 codec idle on bypass", 32'(cdc_in_valid), 0);
      end else begin
        chk(ip_rvalid == 1, "R5 bypass read valid", 32'(ip_rvalid), 1);
        chk(ip_rdata == mem_rdata, "R5 bypass read data", ip_rdata, mem_rdata);
        chk(cdc_in_valid == 0, "R10 codec idle on bypass", 32'(cdc_in_valid), 0);
      end
    end
    @(negedge clk);
    ip_wvalid = 0; mem_rvalid = 0; cdc_out_valid = 0;
    #2;
    chk(ip_done == 1, "R9 done pulse", 32'(ip_done), 1);
    chk(ip_done_len == l, "R9 original length reported", 32'(ip_done_len), 32'(l));
    chk(cfg_ready == 1, "R8 table released", 32'(cfg_ready), 1);
    if (stall) begin
      @(negedge clk);
      cfg_we = 0;
      m_en[3] = 1;
    end
    @(negedge clk);
    #2 chk(ip_done == 0, "R9 single pulse", 32'(ip_done), 0);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_lo[i] = 0; m_hi[i] = 0; m_tg[i] = 0; m_en[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    chk(cfg_ready == 1, "R11 cfg ready after reset", 32'(cfg_ready), 1);
    chk(ip_req_ready == 1, "R11 request ready after reset", 32'(ip_req_ready), 1);
    chk(mem_req_valid == 0, "R11 no memory request", 32'(mem_req_valid), 0);
    chk(ip_done == 0, "R11 no done", 32'(ip_done), 0);
    // unprogrammed table: everything bypasses (R11)
    run_burst(1'b0, 32'h0000_1000, 12'd64, 1'b0);

    cfg_write(0, 0, 32'h1000); cfg_write(0, 1, 32'h2000); cfg_write(0, 2, 64);  cfg_write(0, 3, 1);
    cfg_write(1, 0, 32'h1800); cfg_write(1, 1, 32'h3000); cfg_write(1, 2, 128); cfg_write(1, 3, 1);
    cfg_write(2, 0, 32'h4000); cfg_write(2, 1, 32'h5000); cfg_write(2, 2, 0);   cfg_write(2, 3, 1);
    cfg_write(3, 0, 32'h6000); cfg_write(3, 1, 32'h7000); cfg_write(3, 2, 32);

    run_burst(1'b1, 32'h0000_1000, 12'd128, 1'b0); // R4 R6 ratio 2
    run_burst(1'b0, 32'h0000_1000, 12'd128, 1'b0); // R7
    run_burst(1'b1, 32'h0000_1FFC, 12'd256, 1'b0); // R3 overlap, entry 0 wins
    run_burst(1'b1, 32'h0000_2000, 12'd256, 1'b0); // R2 upper exclusive, entry 1
    run_burst(1'b0, 32'h0000_0FFC, 12'd64,  1'b0); // R2 below lower
    run_burst(1'b1, 32'h0000_4000, 12'd64,  1'b0); // R2 zero target
    run_burst(1'b1, 32'h0000_6000, 12'd64,  1'b0); // R2 disabled
    run_burst(1'b0, 32'h0000_1800, 12'd32,  1'b0); // R4 target above request
    run_burst(1'b0, 32'h0000_0100, 12'd32,  1'b1); // R8 stalled enable, R10 bypass after hit
    run_burst(1'b1, 32'h0000_6000, 12'd128, 1'b0); // R8 stalled write now active

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule